// File: doc/BRIEF.md
# Tri-State Strap Pin Sensor

This block finds out how one pin is strapped on the board. The pin can be tied high, tied low, or left unconnected. The block works this out by driving the pin's internal pull resistor in turn and reading the pad after each change.

A start pulse comes in with a pin index. The block then sets the pin as an input with the pull-up on. It waits a settle time and records the level. Next it switches to the pull-down, waits again and records a second level.

- Two high readings mean the pin is tied high.
- Two low readings mean it is tied low.
- Differing readings mean the pin floats.

When it finishes, the block leaves the pull set to match what it found. It then reports a two-bit level code together with a one-cycle done pulse.

The settle time is 15 microseconds, counted in clock cycles from a clock-frequency parameter. The pad level is taken through a two-flop synchronizer before it is used. An index past the last pin is refused at once with an error pulse, and no pull setting changes.

Top module: `strap_sense`

## Requirements
- R1: After reset the block is idle:
  - `busy_o`, `done_o`, `err_o` and `input_en_o` are low.
  - `pull_o` is 2'b00 (no pull).
- R2: A start pulse with an index below `NUM_PINS`, sampled at a clock edge while the block is idle, has this effect from that edge on:
  - `busy_o` is high and `input_en_o` is high.
  - `pull_o` is 2'b10 (pull-up).
  - `sel_idx_o` equals the index.
- R3: The pull-up phase lasts exactly SETTLE = ceil(CLK_HZ*15/1,000,000) cycles. After it, `pull_o` becomes 2'b01 (pull-down).
- R4: The pull-down phase lasts exactly SETTLE cycles. Then `done_o` is high for exactly one cycle, and `busy_o` falls in that same cycle.
- R5: If the pad reads high at the end of both phases, `level_o` is 2'b01 (logic 1) while `done_o` is high.
- R6: If the pad reads low at the end of both phases, `level_o` is 2'b00 (logic 0) while `done_o` is high.
- R7: If the two readings differ, in either order, `level_o` is 2'b10 (floating) while `done_o` is high.
- R8: From the done cycle on, `pull_o` stays as follows until the next accepted start:
  - 2'b10 (pull-up) when the result is logic 1.
  - 2'b01 (pull-down) otherwise.
  - `input_en_o` stays high.
- R9: A start from idle with an index of `NUM_PINS` or more gives the following:
  - `err_o` is high for one cycle, starting the edge after the start.
  - `busy_o` and `done_o` stay low.
  - `pull_o` and `sel_idx_o` keep their previous values.
- R10: A start that arrives while a read is in progress is ignored. This includes a start in the very cycle whose edge produces `done_o`. The index does not change, the phase lengths do not change, and no new read begins after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, one cycle |
| pin_idx_i | input | IDX_W | Index of the pin to examine |
| pad_i | input | 1 | Level of the selected pad, asynchronous |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| err_o | output | 1 | One-cycle pulse for a refused index |
| level_o | output | 2 | Result: 00 logic 0, 01 logic 1, 10 floating |
| sel_idx_o | output | IDX_W | Pin index that the bank controls apply to |
| input_en_o | output | 1 | Puts the selected pin in input mode |
| pull_o | output | 2 | Pull select: 00 none, 01 down, 10 up |

## Verification
A new start request and the end of a read can fall on the same clock edge, when the second settle window expires. The bench provokes this by raising start exactly one cycle before the done edge. It then judges the outcome at the ports: the done pulse must carry the original result, and `busy_o` must still be low one cycle later. The bench also sends a start in the middle of the pull-up phase with a different index, and checks that `sel_idx_o` and the phase length are unchanged.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    PULL_OFF = 2'b00,
    PULL_DN  = 2'b01,
    PULL_UP  = 2'b10
  } pull_e;

  typedef enum logic [1:0] {
    LVL_0 = 2'b00,
    LVL_1 = 2'b01,
    LVL_Z = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_HI   = 2'b01,
    ST_LO   = 2'b10
  } st_e;
endpackage

// File: rtl/strap_sync2.sv
// Two-flop synchronizer; also used as the reset release stage.
module strap_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/strap_timer.sv
// Settle window counter: load starts a window of SETTLE_CYC cycles,
// exp_o is high in the last cycle of the window.
module strap_timer #(
  parameter longint unsigned SETTLE_CYC = 1875
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic exp_o
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             tick_en;

  assign exp_o   = run_q && (cnt_q == '0);
  assign tick_en = load_i || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = TOP;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP) else $error("count beyond window"); // R3
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (run_q && cnt_q == TOP)) else $error("load did not restart window"); // R3
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
  import strap_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] pin_idx_i,
  input  logic             pad_s_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output lvl_e             level_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             input_en_o,
  output pull_e            pull_o
);
  st_e              st_q, st_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  lvl_e             lvl_q, lvl_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             inp_q, inp_d;
  pull_e            pull_q, pull_d;
  logic             hi_q, hi_d;
  logic             idx_ok;

  assign idx_ok = (int'(pin_idx_i) < NUM_PINS);

  always_comb begin
    st_d       = st_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    lvl_d      = lvl_q;
    sel_d      = sel_q;
    inp_d      = inp_q;
    pull_d     = pull_q;
    hi_d       = hi_q;
    tmr_load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (idx_ok) begin
            st_d       = ST_HI;
            busy_d     = 1'b1;
            sel_d      = pin_idx_i;
            inp_d      = 1'b1;
            pull_d     = PULL_UP;
            tmr_load_o = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_HI: begin
        if (tmr_exp_i) begin
          hi_d       = pad_s_i;
          pull_d     = PULL_DN;
          tmr_load_o = 1'b1;
          st_d       = ST_LO;
        end
      end
      ST_LO: begin
        if (tmr_exp_i) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          done_d = 1'b1;
          if (hi_q && pad_s_i) begin
            lvl_d  = LVL_1;
            pull_d = PULL_UP;
          end else if (!hi_q && !pad_s_i) begin
            lvl_d = LVL_0;
          end else begin
            lvl_d = LVL_Z;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      lvl_q  <= LVL_0;
      sel_q  <= '0;
      inp_q  <= 1'b0;
      pull_q <= PULL_OFF;
      hi_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      lvl_q  <= lvl_d;
      sel_q  <= sel_d;
      inp_q  <= inp_d;
      pull_q <= pull_d;
      hi_q   <= hi_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign level_o    = lvl_q;
  assign sel_idx_o  = sel_q;
  assign input_en_o = inp_q;
  assign pull_o     = pull_q;

  AST_PULL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pull_q != PULL_OFF && inp_q)) else $error("pull off during read"); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R4
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q) else $error("busy fell without done"); // R4
  AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lvl_q != 2'b11)) else $error("illegal level code"); // R5
  AST_FINAL_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pull_q == ((lvl_q == LVL_1) ? PULL_UP : PULL_DN))) else $error("final pull mismatch"); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && !done_q)) else $error("error during read"); // R9
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q)) else $error("index changed mid read"); // R10
endmodule

// File: rtl/strap_sense.sv
module strap_sense
  import strap_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter longint unsigned SETTLE_US = 15,
  parameter int              NUM_PINS  = 40,
  parameter int              IDX_W     = (NUM_PINS < 2) ? 1 : $clog2(NUM_PINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] pin_idx_i,
  input  logic             pad_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       level_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             input_en_o,
  output logic [1:0]       pull_o
);
  localparam longint unsigned RAW_CYC    = (CLK_HZ * SETTLE_US + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned SETTLE_CYC = (RAW_CYC == 0) ? 1 : RAW_CYC;

  logic  rst_int_n;
  logic  pad_s;
  logic  tmr_load;
  logic  tmr_exp;
  lvl_e  lvl;
  pull_e pull;

  strap_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  strap_sync2 #(.RST_VAL(1'b0)) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pad_i),
    .q_o   (pad_s)
  );

  strap_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (tmr_load),
    .exp_o  (tmr_exp)
  );

  strap_fsm #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .pin_idx_i  (pin_idx_i),
    .pad_s_i    (pad_s),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .level_o    (lvl),
    .sel_idx_o  (sel_idx_o),
    .input_en_o (input_en_o),
    .pull_o     (pull)
  );

  assign level_o = lvl;
  assign pull_o  = pull;
endmodule

// File: tb/tb_strap_sense.sv
`timescale 1ns/1ps
module tb_strap_sense;
  localparam int SETTLE = (125_000_000 * 15 + 999_999) / 1_000_000;
  localparam int IDX_W  = 6;

  typedef struct {
    bit         is_err;
    logic [1:0] res;
  } exp_t;

  // ext: 0 tied low, 1 tied high, 2 floating, 3 reads inverted to the pull
  int               ext_mode;
  logic             clk;
  logic             rst_n;
  logic             start;
  logic [IDX_W-1:0] idx;
  logic             pad;
  logic             busy, done, err, inp_en;
  logic [1:0]       level, pull;
  logic [IDX_W-1:0] sel;
  exp_t             sb_q[$];
  int               n_chk;
  int               n_fail;
  bit               mon_on;

  strap_sense dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .pin_idx_i  (idx),
    .pad_i      (pad),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .level_o    (level),
    .sel_idx_o  (sel),
    .input_en_o (inp_en),
    .pull_o     (pull)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    case (ext_mode)
      0:       pad = 1'b0;
      1:       pad = 1'b1;
      2:       pad = (pull == 2'b10);
      default: pad = (pull == 2'b01);
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (mon_on && (done || err)) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected result", done, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(err == e.is_err, "R9", "result kind err", err, e.is_err);
        if (!e.is_err) begin
          chk(level == e.res,
              (e.res == 2'b01) ? "R5" : (e.res == 2'b00) ? "R6" : "R7",
              "level code", level, e.res);
        end
      end
    end
  end

  task automatic run_read(input int pin, input int mode, input logic [1:0] exp_res,
                          input bit poke_mid, input bit poke_end);
    exp_t e;
    int   k;
    e.is_err = 1'b0;
    e.res    = exp_res;
    sb_q.push_back(e);
    ext_mode = mode;
    @(negedge clk);
    start = 1'b1;
    idx   = IDX_W'(pin);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(inp_en == 1'b1, "R2", "input mode", inp_en, 1);
    chk(pull == 2'b10, "R2", "pull-up first", pull, 2);
    chk(sel == IDX_W'(pin), "R2", "selected index", sel, pin);
    k = 0;
    while (pull == 2'b10 && k < 10000) begin
      if (poke_mid && k == 100) begin
        start = 1'b1;
        idx   = IDX_W'(pin ^ 1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == SETTLE, "R3", "pull-up phase cycles", k, SETTLE);
    chk(pull == 2'b01, "R3", "pull-down second", pull, 1);
    if (poke_mid) chk(sel == IDX_W'(pin), "R10", "index after mid start", sel, pin);
    k = 0;
    while (!done && k < 10000) begin
      start = poke_end && (k == SETTLE - 1);
      idx   = IDX_W'(pin);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == SETTLE, "R4", "pull-down phase cycles", k, SETTLE);
    chk(busy == 1'b0, "R4", "busy low at done", busy, 0);
    chk(pull == ((exp_res == 2'b01) ? 2'b10 : 2'b01), "R8", "final pull", pull,
        (exp_res == 2'b01) ? 2 : 1);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done one cycle", done, 0);
    chk(busy == 1'b0, poke_end ? "R10" : "R4", "no restart after done", busy, 0);
    chk(inp_en == 1'b1, "R8", "input mode kept", inp_en, 1);
  endtask

  task automatic bad_index(input int pin);
    exp_t       e;
    logic [1:0] pull_before;
    logic [IDX_W-1:0] sel_before;
    e.is_err    = 1'b1;
    e.res       = 2'b00;
    sb_q.push_back(e);
    pull_before = pull;
    sel_before  = sel;
    @(negedge clk);
    start = 1'b1;
    idx   = IDX_W'(pin);
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R9", "error pulse", err, 1);
    chk(busy == 1'b0 && done == 1'b0, "R9", "no read started", busy, 0);
    chk(pull == pull_before, "R9", "pull unchanged", pull, pull_before);
    chk(sel == sel_before, "R9", "index unchanged", sel, sel_before);
    @(negedge clk);
    chk(err == 1'b0, "R9", "error one cycle", err, 0);
    chk(pull == pull_before, "R9", "pull still unchanged", pull, pull_before);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    mon_on   = 1'b0;
    ext_mode = 0;
    start    = 1'b0;
    idx      = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk(busy == 0 && done == 0 && err == 0, "R1", "idle flags", {busy, done, err}, 0);
    chk(inp_en == 1'b0, "R1", "input mode off", inp_en, 0);
    chk(pull == 2'b00, "R1", "no pull", pull, 0);

    run_read(5, 1, 2'b01, 1'b0, 1'b0);   // R5 tied high
    run_read(0, 0, 2'b00, 1'b0, 1'b0);   // R6 tied low
    run_read(39, 2, 2'b10, 1'b0, 1'b0);  // R7 floating
    run_read(12, 3, 2'b10, 1'b0, 1'b0);  // R7 reversed readings
    bad_index(40);                       // R9 first invalid
    bad_index(63);                       // R9 top of range
    run_read(20, 1, 2'b01, 1'b1, 1'b0);  // R10 start mid read
    run_read(7, 0, 2'b00, 1'b0, 1'b1);   // R10 start at done edge
    run_read(8, 1, 2'b01, 1'b0, 1'b0);   // R8 pull back to up

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4", "all results seen", sb_q.size(), 0);
    finish_up();
  end
endmodule